// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data buses, called A and B, through a pair of multiplexed paths. Each direction owns a capture register with its own clock. The A-side register samples the A bus, and the B-side register samples the B bus. Each bus can then receive either the live value from the opposite bus or the value that the opposite side's register captured earlier. One active-low enable and one direction input decide which bus, if any, is driven. Every channel shares the same controls.

Each bus pin is split into three signals: a received value, a value to drive, and a drive enable. The pad buffer that resolves them lives outside the block. A parameter selects a true or an inverting output path. The registers sample on every rising edge of their clocks, even while both buses are isolated. This lets a system park data in the block and replay it later. The registers have no reset, so they must be loaded before any stored-data mode is used.

Top module: `regbus_xcvr`

## Requirements
- R1: On every rising edge of `clk_a2b`, the A-side register takes the value present on `a_in`.
- R2: On every rising edge of `clk_b2a`, the B-side register takes the value present on `b_in`. An edge on one capture clock leaves the other register unchanged.
- R3: Capture takes place whatever the values of `out_en_n` and `dir_to_b`. This includes capture while that side is being driven, in which case the sampled value is the resolved bus value.
- R4: While `out_en_n` is 1, both `a_oe` and `b_oe` are 0 (isolation). Without a capture edge, the registers keep their contents.
- R5: With `out_en_n` 0 and `dir_to_b` 0, `a_oe` is 1 and `b_oe` is 0.
- R6: With `out_en_n` 0 and `dir_to_b` 1, `b_oe` is 1 and `a_oe` is 0.
- R7: `a_out` carries live `b_in` when `sel_a_stored` is 0, and the B-side register contents when it is 1.
- R8: `b_out` carries live `a_in` when `sel_b_stored` is 0, and the A-side register contents when it is 1.
- R9: With `INVERT` = 0, the output paths pass every bit unchanged. With `INVERT` = 1, every bit of `a_out` and `b_out` is the complement of its selected source.
- R10: The outputs and enables are combinational in the inputs. A newly captured value reaches a stored-data output right after its capture edge, with no further clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a2b | input | 1 | Capture clock for the A-side register (rising edge) |
| clk_b2a | input | 1 | Capture clock for the B-side register (rising edge) |
| out_en_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir_to_b | input | 1 | Direction: 1 drives bus B, 0 drives bus A |
| sel_a_stored | input | 1 | Source for bus A: 0 live B, 1 stored B-side register |
| sel_b_stored | input | 1 | Source for bus B: 0 live A, 1 stored A-side register |
| a_in | input | WIDTH | Resolved value seen on bus A |
| a_out | output | WIDTH | Value offered to bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | WIDTH | Resolved value seen on bus B |
| b_out | output | WIDTH | Value offered to bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The enables and output values are pure logic, so they are due in the same bench cycle as the control or data change that causes them. A stored value is due as soon as its capture edge has passed. The bench changes its inputs on the rising edge of its own clock and raises a capture clock only on a falling edge. It samples outputs on a later falling edge, after the combinational settling and any register update have completed, so every result is checked in the first cycle it is due. Because the bus is split into separate signals, the bench models the resolved bus itself: when a side is driven, it feeds that side's input with the value the design should be driving.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;

   typedef enum logic [1:0] {
      SIDE_NONE = 2'd0,
      SIDE_A    = 2'd1,
      SIDE_B    = 2'd2
   } drive_side_e;

   // Active-low enable wins over direction; direction picks the driven bus.
   function automatic drive_side_e pick_side(input logic out_en_n, input logic dir_to_b);
      if (out_en_n)      return SIDE_NONE;
      else if (dir_to_b) return SIDE_B;
      else               return SIDE_A;
   endfunction

endpackage

// File: rtl/regbus_xcvr_capture.sv
module regbus_xcvr_capture #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   // No reset: contents are undefined until the first capture edge.
   always_ff @(posedge clk) begin
      q <= d;
   end

endmodule

// File: rtl/regbus_xcvr_path.sv
module regbus_xcvr_path #(
   parameter int WIDTH  = 8,
   parameter int INVERT = 0
) (
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   input  logic             use_stored,
   output logic [WIDTH-1:0] y
);

   logic [WIDTH-1:0] pick;

   always_comb begin
      pick = use_stored ? stored : live;
   end

   generate
      if (INVERT != 0) begin : g_inverting
         assign y = ~pick;
      end else begin : g_true
         assign y = pick;
      end
   endgenerate

endmodule

// File: rtl/regbus_xcvr_ctl.sv
module regbus_xcvr_ctl
   import regbus_xcvr_pkg::*;
(
   input  logic out_en_n,
   input  logic dir_to_b,
   output logic a_oe,
   output logic b_oe
);

   drive_side_e side;

   always_comb begin
      side = pick_side(out_en_n, dir_to_b);
      a_oe = (side == SIDE_A);
      b_oe = (side == SIDE_B);
   end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
   parameter int WIDTH  = 8,
   parameter int INVERT = 0
) (
   input  logic             clk_a2b,
   input  logic             clk_b2a,
   input  logic             out_en_n,
   input  logic             dir_to_b,
   input  logic             sel_a_stored,
   input  logic             sel_b_stored,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("regbus_xcvr: WIDTH must be at least 1");
      end
      if (INVERT != 0 && INVERT != 1) begin : g_bad_invert
         $error("regbus_xcvr: INVERT must be 0 or 1");
      end
   endgenerate

   logic [WIDTH-1:0] stored_a;
   logic [WIDTH-1:0] stored_b;

   regbus_xcvr_capture #(.WIDTH(WIDTH)) u_cap_a (
      .clk (clk_a2b),
      .d   (a_in),
      .q   (stored_a)
   );

   regbus_xcvr_capture #(.WIDTH(WIDTH)) u_cap_b (
      .clk (clk_b2a),
      .d   (b_in),
      .q   (stored_b)
   );

   regbus_xcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_path_to_a (
      .live       (b_in),
      .stored     (stored_b),
      .use_stored (sel_a_stored),
      .y          (a_out)
   );

   regbus_xcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_path_to_b (
      .live       (a_in),
      .stored     (stored_a),
      .use_stored (sel_b_stored),
      .y          (b_out)
   );

   regbus_xcvr_ctl u_ctl (
      .out_en_n (out_en_n),
      .dir_to_b (dir_to_b),
      .a_oe     (a_oe),
      .b_oe     (b_oe)
   );

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
   parameter int WIDTH  = 8,
   parameter int INVERT = 0
) (
   input logic             clk_a2b,
   input logic             clk_b2a,
   input logic             out_en_n,
   input logic             dir_to_b,
   input logic             sel_a_stored,
   input logic             sel_b_stored,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] a_out,
   input logic             a_oe,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] b_out,
   input logic             b_oe,
   input logic [WIDTH-1:0] stored_a,
   input logic [WIDTH-1:0] stored_b
);

   localparam logic [WIDTH-1:0] FLIP = {WIDTH{INVERT != 0}};

   // Edge counters arm the checks once each clock has a history.
   logic [1:0] seen_a = 2'd0;
   logic [1:0] seen_b = 2'd0;

   always @(posedge clk_a2b) if (seen_a != 2'd3) seen_a <= seen_a + 2'd1;
   always @(posedge clk_b2a) if (seen_b != 2'd3) seen_b <= seen_b + 2'd1;

   assert_capture_a_R1: assert property (@(posedge clk_a2b) disable iff (seen_a != 2'd3)
      stored_a == $past(a_in));

   assert_capture_b_R2: assert property (@(posedge clk_b2a) disable iff (seen_b != 2'd3)
      stored_b == $past(b_in));

   assert_isolation_R4: assert property (@(posedge clk_a2b) disable iff (seen_a == 2'd0)
      out_en_n |-> (!a_oe && !b_oe));

   assert_drive_a_R5: assert property (@(posedge clk_a2b) disable iff (seen_a == 2'd0)
      (!out_en_n && !dir_to_b) |-> (a_oe && !b_oe));

   assert_drive_b_R6: assert property (@(posedge clk_b2a) disable iff (seen_b == 2'd0)
      (!out_en_n && dir_to_b) |-> (b_oe && !a_oe));

   assert_a_source_R7: assert property (@(posedge clk_b2a) disable iff (seen_b == 2'd0)
      a_oe |-> (a_out == ((sel_a_stored ? stored_b : b_in) ^ FLIP)));

   assert_b_source_R8: assert property (@(posedge clk_a2b) disable iff (seen_a == 2'd0)
      b_oe |-> (b_out == ((sel_b_stored ? stored_a : a_in) ^ FLIP)));

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (
   .clk_a2b      (clk_a2b),
   .clk_b2a      (clk_b2a),
   .out_en_n     (out_en_n),
   .dir_to_b     (dir_to_b),
   .sel_a_stored (sel_a_stored),
   .sel_b_stored (sel_b_stored),
   .a_in         (a_in),
   .a_out        (a_out),
   .a_oe         (a_oe),
   .b_in         (b_in),
   .b_out        (b_out),
   .b_oe         (b_oe),
   .stored_a     (stored_a),
   .stored_b     (stored_b)
);

// File: tb/tb_regbus_xcvr.sv
`timescale 1ns/1ps
module tb_regbus_xcvr;

   localparam int W = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic clk_a2b, clk_b2a, out_en_n, dir_to_b, sel_a_stored, sel_b_stored;
   logic [W-1:0] a_in [2];
   logic [W-1:0] b_in [2];
   logic [W-1:0] a_out [2];
   logic [W-1:0] b_out [2];
   logic         a_oe [2];
   logic         b_oe [2];
   logic [W-1:0] ma [2];
   logic [W-1:0] mb [2];

   int checks = 0;
   int errors = 0;

   regbus_xcvr #(.WIDTH(W), .INVERT(0)) dut (
      .clk_a2b(clk_a2b), .clk_b2a(clk_b2a), .out_en_n(out_en_n), .dir_to_b(dir_to_b),
      .sel_a_stored(sel_a_stored), .sel_b_stored(sel_b_stored),
      .a_in(a_in[0]), .a_out(a_out[0]), .a_oe(a_oe[0]),
      .b_in(b_in[0]), .b_out(b_out[0]), .b_oe(b_oe[0]));

   regbus_xcvr #(.WIDTH(W), .INVERT(1)) dut_inv (
      .clk_a2b(clk_a2b), .clk_b2a(clk_b2a), .out_en_n(out_en_n), .dir_to_b(dir_to_b),
      .sel_a_stored(sel_a_stored), .sel_b_stored(sel_b_stored),
      .a_in(a_in[1]), .a_out(a_out[1]), .a_oe(a_oe[1]),
      .b_in(b_in[1]), .b_out(b_out[1]), .b_oe(b_oe[1]));

   function automatic logic [W-1:0] xf(input logic [W-1:0] v, input int k);
      return (k == 1) ? ~v : v;
   endfunction

   task automatic check_val(input string tag, input int k, input logic [W-1:0] got,
                            input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s variant %0d: got %h expected %h", tag, k, got, exp);
      end
   endtask

   // Drive controls and buses on a rising bench edge; a driven side's input is
   // fed with the value the design should drive (resolved bus model).
   task automatic apply(input logic oen, input logic dir, input logic sa, input logic sb,
                        input logic [W-1:0] av, input logic [W-1:0] bv);
      @(posedge clk);
      out_en_n = oen; dir_to_b = dir; sel_a_stored = sa; sel_b_stored = sb;
      for (int k = 0; k < 2; k++) begin
         a_in[k] = av;
         b_in[k] = bv;
         if (!oen && !dir) a_in[k] = xf(sa ? mb[k] : bv, k);
         if (!oen && dir)  b_in[k] = xf(sb ? ma[k] : av, k);
      end
   endtask

   task automatic tick_a;
      @(negedge clk);
      clk_a2b = 1'b1;
      for (int k = 0; k < 2; k++) ma[k] = a_in[k];
      @(posedge clk);
      clk_a2b = 1'b0;
   endtask

   task automatic tick_b;
      @(negedge clk);
      clk_b2a = 1'b1;
      for (int k = 0; k < 2; k++) mb[k] = b_in[k];
      @(posedge clk);
      clk_b2a = 1'b0;
   endtask

   // Sample away from the rising edge and compare against the model.
   task automatic chk(input string tag);
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         logic ea, eb;
         ea = !out_en_n && !dir_to_b;
         eb = !out_en_n && dir_to_b;
         check_val({tag, " a_oe"}, k, W'(a_oe[k]), W'(ea));
         check_val({tag, " b_oe"}, k, W'(b_oe[k]), W'(eb));
         if (ea) check_val({tag, " a_out"}, k, a_out[k], xf(sel_a_stored ? mb[k] : b_in[k], k));
         if (eb) check_val({tag, " b_out"}, k, b_out[k], xf(sel_b_stored ? ma[k] : a_in[k], k));
      end
   endtask

   task automatic t_isolation;
      apply(1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22);
      chk("R4 isolation dir low");
      apply(1'b1, 1'b1, 1'b1, 1'b1, 8'h33, 8'h44);
      chk("R4 isolation dir high");
   endtask

   task automatic t_load_isolated;
      apply(1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'hA5);
      tick_a;
      tick_b;
      apply(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00);
      chk("R1 R3 R8 stored A shown on B");
      apply(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
      chk("R2 R3 R7 stored B shown on A");
   endtask

   task automatic t_live;
      logic [W-1:0] pats [4] = '{8'h00, 8'hFF, 8'h81, 8'h6E};
      foreach (pats[i]) begin
         apply(1'b0, 1'b0, 1'b0, 1'b0, 8'h55, pats[i]);
         chk("R5 R7 live B to A");
         apply(1'b0, 1'b1, 1'b0, 1'b0, pats[i], 8'h55);
         chk("R6 R8 live A to B");
      end
   endtask

   task automatic t_hold;
      logic [W-1:0] keep_a;
      keep_a = ma[0];
      apply(1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF);
      apply(1'b1, 1'b0, 1'b0, 1'b0, 8'h0F, 8'hF0);
      tick_b;
      apply(1'b0, 1'b1, 1'b0, 1'b1, 8'h99, 8'h00);
      chk("R4 R2 hold A register without its edge");
      @(negedge clk);
      check_val("R4 hold A literal", 0, b_out[0], keep_a);
      apply(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h77);
      chk("R2 B register took the new value");
   endtask

   task automatic t_capture_driven;
      apply(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h5A);
      tick_a;
      apply(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00);
      chk("R3 capture of driven bus A");
      @(negedge clk);
      check_val("R3 driven capture round trip", 0, b_out[0], 8'h5A);
      check_val("R3 driven capture round trip", 1, b_out[1], 8'h5A);
      tick_b;
      apply(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
      chk("R3 capture of driven bus B");
   endtask

   task automatic t_immediate;
      apply(1'b0, 1'b1, 1'b0, 1'b1, 8'h96, 8'h00);
      tick_a;
      chk("R10 stored output follows capture edge");
      apply(1'b0, 1'b1, 1'b0, 1'b0, 8'hC3, 8'h00);
      chk("R10 live output in same cycle");
   endtask

   task automatic t_invert;
      apply(1'b0, 1'b1, 1'b0, 1'b0, 8'h0F, 8'h00);
      @(negedge clk);
      check_val("R9 true path", 0, b_out[0], 8'h0F);
      check_val("R9 inverted path", 1, b_out[1], 8'hF0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      clk_a2b = 1'b0; clk_b2a = 1'b0; out_en_n = 1'b1; dir_to_b = 1'b0;
      sel_a_stored = 1'b0; sel_b_stored = 1'b0;
      for (int k = 0; k < 2; k++) begin
         a_in[k] = '0; b_in[k] = '0; ma[k] = '0; mb[k] = '0;
      end
      t_isolation;
      t_load_isolated;
      t_live;
      t_hold;
      t_capture_driven;
      t_immediate;
      t_invert;
      repeat (2) @(posedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule